// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block collects event pulses from a set of peripheral sources, remembers each one in a pending flag, and presents the single most urgent enabled request to the processor core. Urgency is fixed by table position: source `i` sits at position `i+1`, and the lowest position wins. Position 0 belongs to reset, which outranks every source. The vector address that the block issues is the position times a fixed entry stride, which defaults to four bytes.

The core handshake works as follows. The block raises `irq_req` and holds it while an enabled flag is pending and the global enable is on. The core answers with `irq_ack` once its current instruction has finished. On that acknowledge the block issues the vector for one cycle, clears the global enable, and drops the serviced flag. A `reti` pulse from the core sets the global enable again, and any remaining flags are then served in priority order. Software can also set or clear the global enable directly. Setting it inside a handler allows nesting.

Top module: `vec_irq_ctrl`

## Requirements
- R1: While reset is applied and in the cycle after it is released, `gie`, `irq_req` and `vec_valid` are 0, `pending` is all zero, and `vec_addr` is 0, which is the reset vector.
- R2: A one-cycle pulse on `src_pulse[i]` sets `pending[i]` at the next edge. The flag stays set while `src_en[i]` is 0, and `flag_clr[i]` clears it. When a pulse and a clear arrive in the same cycle, the flag ends up set.
- R3: Serving source `i` issues `vec_addr = (i+1)*4`. For example, source 9 gives 0x28, and no issued vector is ever 0.
- R4: `irq_req` rises one edge after `gie` and some `pending[i] & src_en[i]` are both 1. It stays 0 while either of them is 0.
- R5: Among the flags that are pending and enabled, the one with the lowest index is served. A pending flag whose enable is 0 is passed over, and only one flag is cleared per acknowledge.
- R6: When `irq_ack` is 1 in a cycle where `irq_req` is 1, then at the next edge `vec_valid` pulses for exactly one cycle with the vector, `gie` becomes 0, the served flag clears, and `irq_req` falls. `irq_ack` has no effect while `irq_req` is 0.
- R7: A `reti` pulse sets `gie` at the next edge. The flags left pending are then served one at a time, in priority order.
- R8: `gie_set` sets `gie` and `gie_clr` clears it, and a clear wins over a set. An acknowledge wins over both. Setting `gie` inside a handler lets a pending request be raised again, which gives nesting.
- R9: With `irq_ack` held at 1, `vec_valid` follows exactly two edges after the edge that sets the pending flag, which is within the four-cycle bound.
- R10: If the request condition goes away while `irq_req` is 1 (for example, the source's enable is dropped), `irq_req` falls at the next edge and no vector is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_pulse | input | NUM_SRC | Per-source event pulses |
| src_en | input | NUM_SRC | Per-source enable bits |
| flag_clr | input | NUM_SRC | Software clear of pending flags |
| gie_set | input | 1 | Software set of the global enable |
| gie_clr | input | 1 | Software clear of the global enable |
| irq_ack | input | 1 | Core accepts the request after its current instruction |
| reti | input | 1 | Return-from-interrupt pulse |
| irq_req | output | 1 | Interrupt request to the core |
| vec_valid | output | 1 | One-cycle strobe that marks `vec_addr` as issued |
| vec_addr | output | ADDR_W | Handler vector address |
| gie | output | 1 | Global interrupt enable |
| pending | output | NUM_SRC | Pending flags |

## Verification
The hardest situations to reach are those where several flags are waiting but only one may be served at a time. One case is a higher-priority source whose enable is off while a lower one is enabled. Another is a request that appears while a handler is running with the global enable cleared. The bench holds `irq_ack` low, fires several sources in the same cycle, and then acknowledges one at a time with `reti` in between. This shows each vector in turn. For nesting, it re-enables `gie` with `gie_set` in the middle of a handler. For withdrawal, it drops a source's enable while `irq_req` is raised.

// File: rtl/vic_pkg.sv
package vic_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_REQ  = 1'b1
    } vic_state_e;

endpackage

// File: rtl/vic_pend_flags.sv
module vic_pend_flags #(
    parameter int NUM_SRC = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] set_i,
    input  logic [NUM_SRC-1:0] sw_clr_i,
    input  logic [NUM_SRC-1:0] svc_clr_i,
    output logic [NUM_SRC-1:0] flags_o
);

    typedef struct packed {
        logic [NUM_SRC-1:0] flags;
    } fl_t;

    fl_t                fl_d, fl_q;
    logic [NUM_SRC-1:0] flag_nxt;

    // A new event beats both kinds of clear, so no pulse is lost.
    for (genvar gi = 0; gi < NUM_SRC; gi++) begin : g_flag
        assign flag_nxt[gi] = set_i[gi] |
                              (fl_q.flags[gi] & ~sw_clr_i[gi] & ~svc_clr_i[gi]);
    end

    always_comb begin
        fl_d       = fl_q;
        fl_d.flags = flag_nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) fl_q <= '0;
        else        fl_q <= fl_d;
    end

    assign flags_o = fl_q.flags;

endmodule

// File: rtl/vic_prio_pick.sv
module vic_prio_pick #(
    parameter int NUM_SRC = 12,
    parameter int IDX_W   = 4
) (
    input  logic [NUM_SRC-1:0] cand_i,
    output logic               any_o,
    output logic [IDX_W-1:0]   idx_o,
    output logic [NUM_SRC-1:0] grant_o
);

    // lower_hit[i] is set when some candidate below index i exists.
    logic [NUM_SRC:0] lower_hit;

    assign lower_hit[0] = 1'b0;

    for (genvar gi = 0; gi < NUM_SRC; gi++) begin : g_chain
        assign lower_hit[gi+1] = lower_hit[gi] | cand_i[gi];
        assign grant_o[gi]     = cand_i[gi] & ~lower_hit[gi];
    end

    assign any_o = lower_hit[NUM_SRC];

    always_comb begin
        idx_o = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (grant_o[i]) idx_o = idx_o | IDX_W'(i);
        end
    end

endmodule

// File: rtl/vic_core_ctrl.sv
module vic_core_ctrl
    import vic_pkg::*;
#(
    parameter int NUM_SRC   = 12,
    parameter int IDX_W     = 4,
    parameter int ADDR_W    = 8,
    parameter int STRIDE_SH = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               any_i,
    input  logic [IDX_W-1:0]   idx_i,
    input  logic [NUM_SRC-1:0] grant_i,
    input  logic               gie_set_i,
    input  logic               gie_clr_i,
    input  logic               reti_i,
    input  logic               ack_i,
    output logic               irq_req_o,
    output logic               gie_o,
    output logic [ADDR_W-1:0]  vec_addr_o,
    output logic               vec_valid_o,
    output logic               take_o,
    output logic [NUM_SRC-1:0] svc_clr_o
);

    typedef struct packed {
        vic_state_e         state;
        logic               gie;
        logic [ADDR_W-1:0]  vec_addr;
        logic               vec_valid;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic take;

    always_comb begin
        ctl_d           = ctl_q;
        ctl_d.vec_valid = 1'b0;
        take            = 1'b0;

        unique case (ctl_q.state)
            ST_IDLE: begin
                if (ctl_q.gie && any_i) ctl_d.state = ST_REQ;
            end
            ST_REQ: begin
                if (!(ctl_q.gie && any_i)) begin
                    ctl_d.state = ST_IDLE;
                end else if (ack_i) begin
                    take            = 1'b1;
                    ctl_d.state     = ST_IDLE;
                    ctl_d.vec_valid = 1'b1;
                    // Position 0 is reserved for reset, so source i is at i+1.
                    ctl_d.vec_addr  = (ADDR_W'(idx_i) + ADDR_W'(1)) << STRIDE_SH;
                end
            end
            default: ctl_d.state = ST_IDLE;
        endcase

        if (take)                      ctl_d.gie = 1'b0;
        else if (gie_clr_i)            ctl_d.gie = 1'b0;
        else if (gie_set_i || reti_i)  ctl_d.gie = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q.state     <= ST_IDLE;
            ctl_q.gie       <= 1'b0;
            ctl_q.vec_addr  <= '0;
            ctl_q.vec_valid <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign irq_req_o   = (ctl_q.state == ST_REQ);
    assign gie_o       = ctl_q.gie;
    assign vec_addr_o  = ctl_q.vec_addr;
    assign vec_valid_o = ctl_q.vec_valid;
    assign take_o      = take;
    assign svc_clr_o   = take ? grant_i : '0;

endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl #(
    parameter int NUM_SRC    = 12,
    parameter int VEC_STRIDE = 4,
    parameter int ADDR_W     = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_pulse,
    input  logic [NUM_SRC-1:0] src_en,
    input  logic [NUM_SRC-1:0] flag_clr,
    input  logic               gie_set,
    input  logic               gie_clr,
    input  logic               irq_ack,
    input  logic               reti,
    output logic               irq_req,
    output logic               vec_valid,
    output logic [ADDR_W-1:0]  vec_addr,
    output logic               gie,
    output logic [NUM_SRC-1:0] pending
);

    localparam int IDX_W     = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
    localparam int STRIDE_SH = $clog2(VEC_STRIDE);

    logic [NUM_SRC-1:0] cand_w;
    logic [NUM_SRC-1:0] grant_w;
    logic [NUM_SRC-1:0] svc_clr_w;
    logic [IDX_W-1:0]   idx_w;
    logic               any_w;
    logic               take_w;

    vic_pend_flags #(.NUM_SRC(NUM_SRC)) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_i     (src_pulse),
        .sw_clr_i  (flag_clr),
        .svc_clr_i (svc_clr_w),
        .flags_o   (pending)
    );

    assign cand_w = pending & src_en;

    vic_prio_pick #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_pick (
        .cand_i  (cand_w),
        .any_o   (any_w),
        .idx_o   (idx_w),
        .grant_o (grant_w)
    );

    vic_core_ctrl #(
        .NUM_SRC   (NUM_SRC),
        .IDX_W     (IDX_W),
        .ADDR_W    (ADDR_W),
        .STRIDE_SH (STRIDE_SH)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .any_i       (any_w),
        .idx_i       (idx_w),
        .grant_i     (grant_w),
        .gie_set_i   (gie_set),
        .gie_clr_i   (gie_clr),
        .reti_i      (reti),
        .ack_i       (irq_ack),
        .irq_req_o   (irq_req),
        .gie_o       (gie),
        .vec_addr_o  (vec_addr),
        .vec_valid_o (vec_valid),
        .take_o      (take_w),
        .svc_clr_o   (svc_clr_w)
    );

endmodule

// File: rtl/vic_checks.sv
module vic_checks #(
    parameter int NUM_SRC    = 12,
    parameter int VEC_STRIDE = 4,
    parameter int ADDR_W     = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               irq_req,
    input logic               irq_ack,
    input logic               reti,
    input logic               gie_clr,
    input logic               gie,
    input logic               vec_valid,
    input logic [ADDR_W-1:0]  vec_addr,
    input logic               take,
    input logic [NUM_SRC-1:0] svc_clr
);

    // R6: entering a handler leaves the global enable off
    p_entry_clears_gie_r6: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> !gie);

    // R6: a vector is only issued after a request that was acknowledged
    p_vec_after_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> ($past(irq_req) && $past(irq_ack)));

    // R6: the vector strobe lasts a single cycle
    p_vec_one_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |=> !vec_valid);

    // R4: a request exists only while the global enable was on
    p_req_needs_gie_r4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> $past(gie));

    // R7: return from interrupt restores the global enable
    p_reti_sets_gie_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (reti && !gie_clr && !take) |=> gie);

    // R5: at most one flag is cleared per acknowledge
    p_single_service_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(svc_clr));

    // R3: issued vectors are aligned and never the reset vector
    p_vec_not_reset_r3: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> ((vec_addr != '0) && ((vec_addr % VEC_STRIDE) == 0)));

endmodule

bind vec_irq_ctrl vic_checks #(
    .NUM_SRC    (NUM_SRC),
    .VEC_STRIDE (VEC_STRIDE),
    .ADDR_W     (ADDR_W)
) u_vic_checks (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_req   (irq_req),
    .irq_ack   (irq_ack),
    .reti      (reti),
    .gie_clr   (gie_clr),
    .gie       (gie),
    .vec_valid (vec_valid),
    .vec_addr  (vec_addr),
    .take      (take_w),
    .svc_clr   (svc_clr_w)
);

// File: tb/test_vec_irq_ctrl.sv
module test_vec_irq_ctrl;

    localparam int N  = 12;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [N-1:0]  src_pulse, src_en, flag_clr;
    logic          gie_set, gie_clr, irq_ack, reti;
    logic          irq_req, vec_valid, gie;
    logic [AW-1:0] vec_addr;
    logic [N-1:0]  pending;

    int checks   = 0;
    int failures = 0;
    int cycles   = 0;

    always #2 clk = ~clk;   // 250 MHz
    always @(posedge clk) cycles <= cycles + 1;

    vec_irq_ctrl #(.NUM_SRC(N), .VEC_STRIDE(4), .ADDR_W(AW)) i_vec_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .src_pulse(src_pulse), .src_en(src_en),
        .flag_clr(flag_clr), .gie_set(gie_set), .gie_clr(gie_clr),
        .irq_ack(irq_ack), .reti(reti), .irq_req(irq_req),
        .vec_valid(vec_valid), .vec_addr(vec_addr), .gie(gie),
        .pending(pending)
    );

    task automatic step(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic pulse_src(input logic [N-1:0] m);
        src_pulse = m; step(); src_pulse = '0;
    endtask

    task automatic pulse_reti();
        reti = 1'b1; step(); reti = 1'b0;
    endtask

    task automatic pulse_gie_set();
        gie_set = 1'b1; step(); gie_set = 1'b0;
    endtask

    // acknowledge for one cycle, then verify entry
    task automatic take_one(input int exp_addr, input string tag);
        check({tag, " irq_req before ack"}, 32'(irq_req), 1);
        irq_ack = 1'b1; step(); irq_ack = 1'b0;
        check({tag, " vec_valid"}, 32'(vec_valid), 1);
        check({tag, " vec_addr"}, 32'(vec_addr), 32'(exp_addr));
        check({tag, " gie cleared"}, 32'(gie), 0);
        step();
        check({tag, " vec_valid one cycle"}, 32'(vec_valid), 0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; src_pulse = '0; src_en = '0; flag_clr = '0;
        gie_set = 0; gie_clr = 0; irq_ack = 0; reti = 0;
        step(3);
        rst_n = 1'b1; step();
        check("R1 gie", 32'(gie), 0);
        check("R1 irq_req", 32'(irq_req), 0);
        check("R1 vec_valid", 32'(vec_valid), 0);
        check("R1 vec_addr reset vector", 32'(vec_addr), 0);
        check("R1 pending", 32'(pending), 0);
    endtask

    task automatic t_flag_hold();
        pulse_gie_set();
        src_en = '0;
        pulse_src(N'(1) << 3);
        check("R2 flag set", 32'(pending), 32'h008);
        step(2);
        check("R2 flag held while disabled", 32'(pending), 32'h008);
        check("R4 no req when disabled", 32'(irq_req), 0);
        flag_clr = N'(1) << 3; step(); flag_clr = '0;
        check("R2 sw clear", 32'(pending), 0);
        src_pulse = N'(1) << 5; flag_clr = N'(1) << 5; step();
        src_pulse = '0; flag_clr = '0;
        check("R2 set wins over clear", 32'(pending), 32'h020);
        flag_clr = N'(1) << 5; step(); flag_clr = '0;
    endtask

    task automatic t_single();
        src_en = '1; irq_ack = 1'b1;
        pulse_src(N'(1) << 9);
        check("R9 flag visible", 32'(pending[9]), 1);
        check("R4 req not yet", 32'(irq_req), 0);
        step();
        check("R4 req raised", 32'(irq_req), 1);
        step();
        check("R9 vector after two edges", 32'(vec_valid), 1);
        check("R3 vector for source 9", 32'(vec_addr), 32'h28);
        check("R6 gie cleared", 32'(gie), 0);
        check("R6 flag cleared", 32'(pending), 0);
        check("R6 req dropped", 32'(irq_req), 0);
        irq_ack = 1'b0;
        step();
        check("R6 strobe single", 32'(vec_valid), 0);
        pulse_reti();
        check("R7 reti sets gie", 32'(gie), 1);
    endtask

    task automatic t_ack_ignored();
        irq_ack = 1'b1; step(2); irq_ack = 1'b0;
        check("R6 ack without req: no vector", 32'(vec_valid), 0);
        check("R6 ack without req: gie kept", 32'(gie), 1);
    endtask

    task automatic t_priority();
        src_en = '1; src_en[1] = 1'b0;
        pulse_src((N'(1) << 1) | (N'(1) << 4) | (N'(1) << 7));
        step();
        take_one(20, "R5 lowest enabled wins");
        check("R5 others stay pending", 32'(pending), 32'h082);
        step(2);
        check("R7 no req until reti", 32'(irq_req), 0);
        pulse_reti(); step();
        take_one(32, "R7 next in order");
        pulse_reti(); step(2);
        check("R5 disabled source passed over", 32'(irq_req), 0);
        src_en[1] = 1'b1; step();
        take_one(8, "R5 enabled later");
        pulse_reti();
    endtask

    task automatic t_nested();
        src_en = '1;
        pulse_src(N'(1) << 6); step();
        take_one(28, "R8 outer handler");
        pulse_src(N'(1) << 2); step(2);
        check("R8 no nesting with gie off", 32'(irq_req), 0);
        pulse_gie_set();
        check("R8 gie_set", 32'(gie), 1);
        step();
        take_one(12, "R8 nested entry");
        gie_set = 1'b1; gie_clr = 1'b1; step(); gie_set = 0; gie_clr = 0;
        check("R8 clear beats set", 32'(gie), 0);
        pulse_reti();
        pulse_src(N'(1) << 0); step();
        check("R8 req before ack", 32'(irq_req), 1);
        irq_ack = 1'b1; gie_set = 1'b1; step(); irq_ack = 0; gie_set = 0;
        check("R8 ack beats set: vector", 32'(vec_addr), 4);
        check("R8 ack beats set: gie", 32'(gie), 0);
        pulse_reti();
    endtask

    task automatic t_withdraw();
        src_en = '1;
        pulse_src(N'(1) << 8); step();
        check("R10 req up", 32'(irq_req), 1);
        src_en[8] = 1'b0; step();
        check("R10 req withdrawn", 32'(irq_req), 0);
        irq_ack = 1'b1; step(); irq_ack = 1'b0;
        check("R10 no vector", 32'(vec_valid), 0);
        check("R10 flag still pending", 32'(pending), 32'h100);
        flag_clr = N'(1) << 8; step(); flag_clr = '0;
    endtask

    initial begin
        t_reset();
        t_flag_hold();
        t_single();
        t_ack_ignored();
        t_priority();
        t_nested();
        t_withdraw();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        wait (cycles > 20000);
        failures++;
        $display("FAIL watchdog expired actual=%0d expected<20000", cycles);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule